// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Sequencer

This block sits on the system side of a small serial nonvolatile memory that is reached over three wires: an enable line, a shift clock and one bidirectional data line. It accepts one command at a time on a valid/ready interface and turns it into pin activity. The four command kinds are read, erase, write, and erase followed by write. When the command finishes, the block reports completion with a one-cycle strobe and, for a read, the byte fetched from the memory.

Every interval on the wires is a number of system-clock cycles set by a parameter. These intervals are the clock high and low times, the hold after a clock falling edge, the spacing around enable edges, the programming time and the recovery time. Frame bits are shifted out least significant bit first while enable is high. Enable is then dropped with the operation-select level already on the data line. A single start pulse follows. For a read, a load pulse and eight clocks follow instead. For erase-then-write, the data and address are sent once, and the block runs the erase period and then the write period.

Top module: `ee3w_host`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `mem_ce` is 1, `mem_clk` is 0, `mem_d_oe` is 0, `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: `cmd_op` selects the operation: 0 read, 1 erase, 2 write, 3 erase-then-write. The frame is shifted LSB first while `mem_ce` is high, and the memory takes each bit at a `mem_clk` falling edge. A read frame has 8 bits: address A0..A6, then a control bit of 0. An erase frame has 8 bits: the address, then a control bit of 1. A write or erase-then-write frame has 16 bits: data D0..D7, then the address, then a control bit of 1.
- R3: Every `mem_clk` high phase lasts exactly T_HI cycles. Every low phase before a rising edge lasts at least T_LO cycles.
- R4: `mem_ce` changes only while `mem_clk` is low. Each `mem_ce` edge is at least T_CE_CLK cycles from any `mem_clk` edge. Each `mem_ce` edge is at least T_CE_D cycles from any change of the driven data level.
- R5: While `mem_ce` is high, the driven data changes only while `mem_clk` is low, and no earlier than T_HD cycles after a falling edge.
- R6: In an erase or write period the data line is driven 1 (erase) or 0 (write). It holds that level from the `mem_ce` falling edge through the falling edge of the start pulse. Exactly one start pulse is given, and `mem_ce` rises no sooner than T_PROG cycles after that pulse falls.
- R7: Erase-then-write sends one 16-bit frame and then two enable periods: the first with the data line high (erase), the second with the line low (write). The stored word then equals the data byte.
- R8: A read releases the data driver at the rising edge of the load pulse, then gives eight further clocks. Bit k of `rsp_rdata` is the line level sampled T_HD cycles after the k-th falling edge, counting the load pulse as k=0.
- R9: `cmd_ready` stays low from acceptance until T_REC cycles after `mem_ce` returns high. In the cycle `cmd_ready` rises, `rsp_valid` is high for one cycle. `rsp_rdata` then holds the read byte, or zero for the other operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 2 | Operation code (R2) |
| cmd_addr | input | AW | Word address |
| cmd_wdata | input | DW | Byte to write |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | DW | Byte read, zero for other operations |
| mem_ce | output | 1 | Enable line to the memory |
| mem_clk | output | 1 | Shift clock to the memory |
| mem_d_out | output | 1 | Level driven onto the data line |
| mem_d_oe | output | 1 | Data line driver enable |
| mem_d_in | input | 1 | Level sensed on the data line |

## Verification
The hardest case to reach from the ports is the second enable period of erase-then-write. There the block must drop enable again with the line low and no new frame, and the memory must apply the data it still holds in its shift register. The bench contains a pin-level memory model that keeps its own shift register and storage. Erase-then-write commands are aimed at words whose earlier contents differ from the new byte. A readback then exposes a missing, repeated or mis-levelled period, and a per-command count of programming enables must come out at two.

// File: rtl/ee3w_pkg.sv
package ee3w_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_ERASE = 2'd1,
    OP_WRITE = 2'd2,
    OP_ERWR  = 2'd3
  } ee_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SH_LO,
    S_SH_HI,
    S_SH_HOLD,
    S_SEL,
    S_ENA,
    S_PULSE,
    S_PROG,
    S_GAP,
    S_RD_DLY,
    S_RD_LO,
    S_RD_HI,
    S_DIS,
    S_REC
  } ee_st_e;

  function automatic int unsigned imax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ee3w_timer.sv
module ee3w_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/ee3w_txshift.sv
module ee3w_txshift #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         nxt
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= din;
    else if (shift) sr <= {1'b0, sr[W-1:1]};
  end

  // bit that goes onto the line after the next shift
  assign nxt = sr[1];
endmodule

// File: rtl/ee3w_rxshift.sv
module ee3w_rxshift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         sample,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr)  q <= '0;
    else if (sample) q <= {din, q[W-1:1]};
  end
endmodule

// File: rtl/ee3w_host.sv
module ee3w_host
  import ee3w_pkg::*;
#(
  parameter int unsigned AW       = 7,
  parameter int unsigned DW       = 8,
  parameter int unsigned T_HI     = 750,
  parameter int unsigned T_LO     = 1500,
  parameter int unsigned T_HD     = 750,
  parameter int unsigned T_CE_CLK = 1500,
  parameter int unsigned T_CE_D   = 750,
  parameter int unsigned T_PROG   = 3000000,
  parameter int unsigned T_REC    = 1500
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_ce,
  output logic          mem_clk,
  output logic          mem_d_out,
  output logic          mem_d_oe,
  input  logic          mem_d_in
);
  localparam int unsigned FW    = DW + AW + 1;
  localparam int unsigned SW    = AW + 1;
  localparam int unsigned NB_W  = $clog2(FW);
  localparam int unsigned RC_W  = $clog2(DW);
  localparam int unsigned T_SEL = imax(T_CE_D, T_CE_CLK);
  localparam int unsigned T_ENA = imax(T_CE_CLK, T_LO);
  localparam int unsigned TMAX  = imax(imax(imax(T_HI, T_LO), imax(T_PROG, T_REC)),
                                       imax(imax(T_SEL, T_ENA), T_HD));
  localparam int unsigned TW    = $clog2(TMAX + 1);

  localparam logic [TW-1:0] V_HI   = TW'(T_HI - 1);
  localparam logic [TW-1:0] V_LO   = TW'(T_LO - 1);
  localparam logic [TW-1:0] V_LO2  = TW'(T_LO - T_HD - 1);
  localparam logic [TW-1:0] V_HD   = TW'(T_HD - 1);
  localparam logic [TW-1:0] V_SEL  = TW'(T_SEL - 1);
  localparam logic [TW-1:0] V_ENA  = TW'(T_ENA - 1);
  localparam logic [TW-1:0] V_CC   = TW'(T_CE_CLK - 1);
  localparam logic [TW-1:0] V_CD   = TW'(T_CE_D - 1);
  localparam logic [TW-1:0] V_PROG = TW'(T_PROG - 1);
  localparam logic [TW-1:0] V_REC  = TW'(T_REC - 1);

  ee_st_e            st, st_n;
  ee_op_e            op_q, op_in;
  logic              sec_q, sec_set;
  logic [NB_W-1:0]   bits_left;
  logic [RC_W-1:0]   rd_cnt;
  logic              cnt_inc, acc, shift, samp;
  logic              tmr_load, tmr_done;
  logic [TW-1:0]     tmr_val;
  logic              tx_nxt;
  logic [DW-1:0]     rx_q;
  logic [FW-1:0]     frame;
  logic              ce_n, ck_n, d_n, oe_n, rdy_n, rv_n;
  logic              sel_lvl, is_rd;

  assign op_in   = ee_op_e'(cmd_op);
  assign is_rd   = (op_q == OP_READ);
  assign sel_lvl = (op_q == OP_ERASE) || ((op_q == OP_ERWR) && !sec_q);

  // frame image, bit 0 goes out first
  always_comb begin
    frame = '0;
    unique case (op_in)
      OP_READ:  frame[SW-1:0] = {1'b0, cmd_addr};
      OP_ERASE: frame[SW-1:0] = {1'b1, cmd_addr};
      default:  frame         = {1'b1, cmd_addr, cmd_wdata};
    endcase
  end

  ee3w_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .done(tmr_done)
  );

  ee3w_txshift #(.W(FW)) u_tx (
    .clk(clk), .rst(rst), .load(acc), .shift(shift), .din(frame), .nxt(tx_nxt)
  );

  ee3w_rxshift #(.W(DW)) u_rx (
    .clk(clk), .rst(rst), .clr(acc), .sample(samp), .din(mem_d_in), .q(rx_q)
  );

  always_comb begin
    st_n     = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    ce_n     = mem_ce;
    ck_n     = mem_clk;
    d_n      = mem_d_out;
    oe_n     = mem_d_oe;
    rdy_n    = cmd_ready;
    rv_n     = 1'b0;
    acc      = 1'b0;
    shift    = 1'b0;
    samp     = 1'b0;
    sec_set  = 1'b0;
    cnt_inc  = 1'b0;
    unique case (st)
      S_IDLE: if (cmd_valid && cmd_ready) begin
        acc = 1'b1; d_n = frame[0]; oe_n = 1'b1; rdy_n = 1'b0;
        tmr_load = 1'b1; tmr_val = V_LO; st_n = S_SH_LO;
      end
      S_SH_LO: if (tmr_done) begin
        ck_n = 1'b1; tmr_load = 1'b1; tmr_val = V_HI; st_n = S_SH_HI;
      end
      S_SH_HI: if (tmr_done) begin
        ck_n = 1'b0; tmr_load = 1'b1; tmr_val = V_HD; st_n = S_SH_HOLD;
      end
      S_SH_HOLD: if (tmr_done) begin
        tmr_load = 1'b1;
        if (bits_left != '0) begin
          shift = 1'b1; d_n = tx_nxt; tmr_val = V_LO2; st_n = S_SH_LO;
        end else begin
          d_n = sel_lvl; tmr_val = V_SEL; st_n = S_SEL;
        end
      end
      S_SEL: if (tmr_done) begin
        ce_n = 1'b0; tmr_load = 1'b1; tmr_val = V_ENA; st_n = S_ENA;
      end
      S_ENA: if (tmr_done) begin
        ck_n = 1'b1;
        if (is_rd) oe_n = 1'b0;
        tmr_load = 1'b1; tmr_val = V_HI; st_n = S_PULSE;
      end
      S_PULSE: if (tmr_done) begin
        ck_n = 1'b0; tmr_load = 1'b1;
        if (is_rd) begin tmr_val = V_HD;   st_n = S_RD_DLY; end
        else       begin tmr_val = V_PROG; st_n = S_PROG;   end
      end
      S_PROG: if (tmr_done) begin
        ce_n = 1'b1; tmr_load = 1'b1;
        if ((op_q == OP_ERWR) && !sec_q) begin
          sec_set = 1'b1; tmr_val = V_CD; st_n = S_GAP;
        end else begin
          tmr_val = V_REC; st_n = S_REC;
        end
      end
      S_GAP: if (tmr_done) begin
        d_n = 1'b0; tmr_load = 1'b1; tmr_val = V_SEL; st_n = S_SEL;
      end
      S_RD_DLY: if (tmr_done) begin
        samp = 1'b1; tmr_load = 1'b1; tmr_val = V_LO2; st_n = S_RD_LO;
      end
      S_RD_LO: if (tmr_done) begin
        ck_n = 1'b1; tmr_load = 1'b1; tmr_val = V_HI; st_n = S_RD_HI;
      end
      S_RD_HI: if (tmr_done) begin
        ck_n = 1'b0; cnt_inc = 1'b1; tmr_load = 1'b1;
        if (rd_cnt == RC_W'(DW - 1)) begin tmr_val = V_CC; st_n = S_DIS;    end
        else                         begin tmr_val = V_HD; st_n = S_RD_DLY; end
      end
      S_DIS: if (tmr_done) begin
        ce_n = 1'b1; tmr_load = 1'b1; tmr_val = V_REC; st_n = S_REC;
      end
      S_REC: if (tmr_done) begin
        oe_n = 1'b0; rdy_n = 1'b1; rv_n = 1'b1; st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      op_q      <= OP_READ;
      sec_q     <= 1'b0;
      bits_left <= '0;
      rd_cnt    <= '0;
      mem_ce    <= 1'b1;
      mem_clk   <= 1'b0;
      mem_d_out <= 1'b0;
      mem_d_oe  <= 1'b0;
      cmd_ready <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      st        <= st_n;
      mem_ce    <= ce_n;
      mem_clk   <= ck_n;
      mem_d_out <= d_n;
      mem_d_oe  <= oe_n;
      cmd_ready <= rdy_n;
      rsp_valid <= rv_n;
      if (acc) begin
        op_q      <= op_in;
        sec_q     <= 1'b0;
        rd_cnt    <= '0;
        bits_left <= ((op_in == OP_READ) || (op_in == OP_ERASE)) ? NB_W'(SW - 1) : NB_W'(FW - 1);
      end else begin
        if (shift)   bits_left <= bits_left - 1'b1;
        if (sec_set) sec_q     <= 1'b1;
        if (cnt_inc) rd_cnt    <= rd_cnt + 1'b1;
      end
      if (rv_n) rsp_rdata <= is_rd ? rx_q : '0;
    end
  end
endmodule

// File: rtl/ee3w_host_chk.sv
module ee3w_host_chk #(
  parameter int unsigned T_HI = 750
) (
  input logic clk,
  input logic rst,
  input logic cmd_ready,
  input logic rsp_valid,
  input logic mem_ce,
  input logic mem_clk,
  input logic mem_d_out,
  input logic mem_d_oe
);
  localparam int unsigned CW = $clog2(T_HI + 2);
  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)          hi_cnt <= '0;
    else if (mem_clk) hi_cnt <= hi_cnt + 1'b1;
    else              hi_cnt <= '0;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (mem_ce && !mem_clk && !mem_d_oe && cmd_ready && !rsp_valid));

  p_high_width_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_clk) |-> (hi_cnt == CW'(T_HI)));

  p_ce_clock_low_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_ce != $past(mem_ce)) |-> (!mem_clk && !$past(mem_clk)));

  p_d_still_high_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_clk && $past(mem_clk) && mem_d_oe && $past(mem_d_oe)) |-> $stable(mem_d_out));

  p_select_held_r6: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce && !$past(mem_ce) && mem_d_oe && $past(mem_d_oe)) |-> $stable(mem_d_out));

  p_release_on_load_r8: assert property (@(posedge clk) disable iff (rst)
    ($fell(mem_d_oe) && !mem_ce) |-> $rose(mem_clk));

  p_busy_enabled_r9: assert property (@(posedge clk) disable iff (rst)
    !mem_ce |-> !cmd_ready);

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_ready_with_done_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_ready) |-> rsp_valid);
endmodule

bind ee3w_host ee3w_host_chk #(.T_HI(T_HI)) i_ee3w_host_chk (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
  .mem_ce(mem_ce), .mem_clk(mem_clk), .mem_d_out(mem_d_out), .mem_d_oe(mem_d_oe)
);

// File: tb/test_ee3w_host.sv
module test_ee3w_host;
  localparam int P_HI = 4, P_LO = 8, P_HD = 3, P_CC = 6, P_CD = 4, P_PROG = 200, P_REC = 10;

  typedef struct packed { logic [1:0] op; logic [7:0] data; } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [6:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = '0;
  logic cmd_ready, rsp_valid, mem_ce, mem_clk, mem_d_out, mem_d_oe, mem_d_in;
  logic [7:0] rsp_rdata;

  int n_chk = 0, n_err = 0, cyc = 0;
  exp_t q[$];
  logic [7:0] sh_mem [128];

  // memory model state
  logic [7:0]  m_mem [128];
  logic [15:0] m_sr = '0;
  logic [7:0]  m_rsr = '0;
  logic [6:0]  m_addr = '0;
  logic m_drv = 1'b0, m_bit = 1'b1, m_sel = 1'b0;
  int m_mode = 0, m_pulses = 0, m_falls = 0, falls_seen = 0;
  int t_clk = -1000, t_fall = -1000, t_ce = -1000, t_d = -1000, t_start = -1000, t_cer = -1000;
  logic pc = 1'b0, pce = 1'b1, pd = 1'b0, poe = 1'b0, prdy = 1'b1;

  always #2 clk = ~clk;

  assign mem_d_in = mem_d_oe ? mem_d_out : (m_drv ? m_bit : 1'b1);

  ee3w_host #(.T_HI(P_HI), .T_LO(P_LO), .T_HD(P_HD), .T_CE_CLK(P_CC),
              .T_CE_D(P_CD), .T_PROG(P_PROG), .T_REC(P_REC)) i_ee3w_host (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce(mem_ce),
    .mem_clk(mem_clk), .mem_d_out(mem_d_out), .mem_d_oe(mem_d_oe), .mem_d_in(mem_d_in)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      m_mem[i]  = 8'(i * 37 + 11);
      sh_mem[i] = 8'((i * 37 + 11) % 256);
    end
  end

  // pin-level memory model, timing monitor and response scoreboard
  always @(negedge clk) begin
    exp_t e;
    cyc++;
    if (rst) begin
      m_mode = 0; m_drv = 1'b0;
      pc = mem_clk; pce = mem_ce; pd = mem_d_out; poe = mem_d_oe; prdy = cmd_ready;
    end else begin
      if (mem_d_oe && poe && (mem_d_out != pd)) begin
        chk(cyc - t_ce >= P_CD, "R4", "enable to data spacing", cyc - t_ce, P_CD);
        if (mem_ce) chk(!mem_clk && (cyc - t_fall >= P_HD), "R5", "data hold after fall", cyc - t_fall, P_HD);
        t_d = cyc;
      end
      if (m_mode == 2 && m_pulses == 0)
        chk(mem_d_in == m_sel, "R6", "select level held", mem_d_in, m_sel);
      if (mem_clk && !pc) begin
        chk(cyc - t_clk >= P_LO, "R3", "clock low width", cyc - t_clk, P_LO);
        chk(cyc - t_ce >= P_CC, "R4", "enable to clock spacing", cyc - t_ce, P_CC);
        t_clk = cyc;
        if (!mem_ce && m_mode == 1 && m_pulses == 0) m_rsr = m_mem[m_addr];
      end
      if (!mem_clk && pc) begin
        chk(cyc - t_clk == P_HI, "R3", "clock high width", cyc - t_clk, P_HI);
        t_clk = cyc; t_fall = cyc;
        if (mem_ce) m_sr = {mem_d_in, m_sr[15:1]};
        else if (m_mode == 1) begin
          if (m_pulses != 0) m_rsr = m_rsr >> 1;
          m_drv = 1'b1; m_bit = m_rsr[0]; m_pulses++;
        end else if (m_mode == 2) begin
          m_pulses++; t_start = cyc;
        end
      end
      if (mem_ce != pce) begin
        chk(cyc - t_clk >= P_CC, "R4", "clock to enable spacing", cyc - t_clk, P_CC);
        chk(cyc - t_d >= P_CD, "R4", "data to enable spacing", cyc - t_d, P_CD);
        t_ce = cyc;
        if (!mem_ce) begin
          m_addr = m_sr[14:8]; m_pulses = 0;
          if (m_sr[15]) begin m_mode = 2; m_sel = mem_d_in; m_falls++; end
          else m_mode = 1;
        end else begin
          if (m_mode == 2) begin
            chk(m_pulses == 1, "R6", "start pulses", m_pulses, 1);
            chk(cyc - t_start >= P_PROG, "R6", "program time", cyc - t_start, P_PROG);
            if (m_sel) m_mem[m_addr] = 8'hFF;
            else       m_mem[m_addr] = m_mem[m_addr] & m_sr[7:0];
          end else if (m_mode == 1) begin
            chk(m_pulses == 9, "R8", "read clock count", m_pulses, 9);
          end
          m_mode = 0; m_drv = 1'b0; t_cer = cyc;
        end
      end
      if (cmd_ready && !prdy) begin
        chk(cyc - t_cer >= P_REC, "R9", "recovery before ready", cyc - t_cer, P_REC);
        chk(rsp_valid, "R9", "done with ready", rsp_valid, 1);
      end
      if (rsp_valid) begin
        if (q.size() == 0) chk(1'b0, "R9", "unexpected done", 1, 0);
        else begin
          e = q.pop_front();
          if (e.op == 2'd0) chk(rsp_rdata == e.data, "R8", "read byte", rsp_rdata, e.data);
          else              chk(rsp_rdata == e.data, "R9", "non-read data zero", rsp_rdata, e.data);
          if (e.op == 2'd3) chk(m_falls - falls_seen == 2, "R7", "program periods", m_falls - falls_seen, 2);
          else chk(m_falls - falls_seen == ((e.op == 2'd0) ? 0 : 1), "R6", "program periods",
                   m_falls - falls_seen, (e.op == 2'd0) ? 0 : 1);
          falls_seen = m_falls;
        end
      end
      pc = mem_clk; pce = mem_ce; pd = mem_d_out; poe = mem_d_oe; prdy = cmd_ready;
    end
  end

  // driver: issues a command and pushes the expected response
  task automatic issue(input logic [1:0] op, input logic [6:0] a, input logic [7:0] d);
    exp_t e;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    e.op = op; e.data = 8'h00;
    case (op)
      2'd0: e.data = sh_mem[a];
      2'd1: sh_mem[a] = 8'hFF;
      2'd2: sh_mem[a] = sh_mem[a] & d;
      default: sh_mem[a] = d;
    endcase
    q.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R9", "ready drops on accept", cmd_ready, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_ce == 1'b1, "R1", "enable high", mem_ce, 1);
    chk(mem_clk == 1'b0, "R1", "clock low", mem_clk, 0);
    chk(mem_d_oe == 1'b0, "R1", "driver off", mem_d_oe, 0);
    chk(cmd_ready == 1'b1 && rsp_valid == 1'b0, "R1", "ready, no done", cmd_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_ce && !mem_clk && cmd_ready, "R1", "idle after reset", mem_ce, 1);
    // R2 R8 reads of initial content
    issue(2'd0, 7'd0, 8'h00);
    issue(2'd0, 7'd5, 8'h00);
    issue(2'd0, 7'd127, 8'h00);
    // R6 erase then readback
    issue(2'd1, 7'd5, 8'h00);
    issue(2'd0, 7'd5, 8'h00);
    // R6 write on erased word and write-only clearing
    issue(2'd2, 7'd5, 8'hA5);
    issue(2'd0, 7'd5, 8'h00);
    issue(2'd2, 7'd6, 8'h0F);
    issue(2'd0, 7'd6, 8'h00);
    // R7 erase-then-write at several words
    issue(2'd3, 7'd127, 8'h3C);
    issue(2'd0, 7'd127, 8'h00);
    issue(2'd3, 7'd0, 8'h00);
    issue(2'd0, 7'd0, 8'h00);
    issue(2'd3, 7'd64, 8'h96);
    issue(2'd0, 7'd64, 8'h00);
    issue(2'd0, 7'd85, 8'h00);
    @(negedge clk);
    while (q.size() != 0 || !cmd_ready) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(mem_ce && !mem_clk && !mem_d_oe, "R9", "back to idle", mem_ce, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule